// File: doc/BRIEF.md
# Multi-Queue Event Ring Writer

The block turns event strobes into 32-bit records and writes them into circular tables held in a small on-chip synchronous RAM. There is one transmit table and four receive tables. A receive event is routed to one of the four receive tables. The table is chosen by a 2-bit queue number that configuration assigns to each channel. A transmit event always lands in the transmit table.

Software owns the table memory through a second RAM port. It polls the tables, consumes records and hands slots back by clearing everything except the wrap bit. The table length is never programmed as a number. The writer keeps writing forward until it writes a slot whose stored wrap bit is set, and then returns to that table's base. Before each write, the writer reads the slot at its pointer. If software still holds that slot, the writer leaves it untouched and raises an overflow pulse for that table. Receive frame completions are coalesced: a reload counter raises a receive interrupt once per programmed number of completed frames.

Each event source uses a valid/ready handshake. Transmit events win over receive events, and every accepted event occupies the writer for two cycles: one to read the slot and one to write it.

Top module: `ring_event_writer`

## Requirements
- R1: A written record has the valid flag set in bit 31, a copy of the slot's stored wrap flag in bit 30, the 16 event flags in bits 29:14, the 8-bit channel number in bits 13:6, and zeros in bits 5:0.
- R2: After writing a slot whose stored wrap bit is 1, the pointer of that table returns to its base address. Otherwise it advances by one. The wrap bit is preserved in the written record.
- R3: A transmit event goes to table 0. A receive event goes to receive queue `chan_qmap[2*c+1:2*c]`, where c is the low log2(NCH) bits of the channel number.
- R4: A coalescing counter is loaded from `rx_thresh`, with 0 treated as 1. It decrements for each written receive record whose `rx_ev_last` was set. When it would reach zero, `rx_irq` pulses for one cycle and the counter reloads.
- R5: A slot whose bit 31 is 1 when the writer checks it is not modified, and the table pointer does not move.
- R6: An event that finds its slot held raises a one-cycle pulse on `ovf` bit 0 (transmit) or bit 1+q (receive queue q), in the cycle after the check. At most one bit is set.
- R7: While `tx_ev_valid` is high, `rx_ev_ready` is low.
- R8: Ready is only offered in the idle state. After an event is accepted, neither source is ready in the next cycle.
- R9: While `en` is low, no event is accepted, every pointer is loaded from its base and the coalescing counter is loaded from the threshold.
- R10: `tx_irq` pulses for one cycle after each transmit record is written, and not for overflowed events.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Writer enable; low reloads pointers and counter |
| tx_base | input | AW | Base address of the transmit table |
| rx_base | input | 4*AW | Base addresses of receive queues 0..3, queue 0 in the low bits |
| chan_qmap | input | 2*NCH | Receive queue number of each channel, 2 bits per channel |
| rx_thresh | input | CW | Coalescing threshold in frames |
| tx_ev_valid | input | 1 | Transmit event present |
| tx_ev_ready | output | 1 | Transmit event accepted this cycle when valid |
| tx_ev_chan | input | 8 | Transmit event channel |
| tx_ev_flags | input | 16 | Transmit event flags |
| rx_ev_valid | input | 1 | Receive event present |
| rx_ev_ready | output | 1 | Receive event accepted this cycle when valid |
| rx_ev_chan | input | 8 | Receive event channel |
| rx_ev_flags | input | 16 | Receive event flags |
| rx_ev_last | input | 1 | Receive event completes a frame |
| sw_en | input | 1 | Software port access |
| sw_we | input | 1 | Software port write |
| sw_addr | input | AW | Software port address |
| sw_wdata | input | 32 | Software port write data |
| sw_rdata | output | 32 | Software port read data, one cycle after the access |
| tx_irq | output | 1 | Transmit record written pulse |
| rx_irq | output | 1 | Coalesced receive interrupt pulse |
| ovf | output | 5 | Per-table overflow pulses |

## Verification
Two functions can fall in the same cycle: the arbitration between the two sources, and the completion of the previous event's write with its interrupt. The bench raises both valids on one edge. It then judges the grant order from the ready lines, and checks that the transmit interrupt appears in the same cycle in which the waiting receive event is first offered ready. A second collision is between software release and the writer's ownership check. The bench lets a small queue fill before draining it and expects an overflow pulse exactly on the event that finds an unreleased slot. It then confirms that the held record reads back unchanged.

// File: rtl/ring_pkg.sv
package ring_pkg;
    localparam int ENT_W  = 32;
    localparam int FLAG_W = 16;
    localparam int CHAN_W = 8;
    localparam int NRXQ   = 4;
    localparam int NQ     = NRXQ + 1;
    localparam int QW     = $clog2(NQ);

    typedef struct packed {
        logic              valid;
        logic              wrap;
        logic [FLAG_W-1:0] flags;
        logic [CHAN_W-1:0] chan;
        logic [5:0]        pad;
    } ring_entry_t;

    typedef enum logic {ST_IDLE, ST_CHECK} wr_state_e;

    function automatic ring_entry_t make_entry(input logic wrap,
                                               input logic [FLAG_W-1:0] flags,
                                               input logic [CHAN_W-1:0] chan);
        ring_entry_t e;
        e.valid = 1'b1;
        e.wrap  = wrap;
        e.flags = flags;
        e.chan  = chan;
        e.pad   = '0;
        return e;
    endfunction
endpackage

// File: rtl/ring_ram.sv
module ring_ram #(
    parameter int AW = 6,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic [AW-1:0] a_addr,
    input  logic          a_we,
    input  logic [DW-1:0] a_wdata,
    output logic [DW-1:0] a_rdata,
    input  logic          b_en,
    input  logic          b_we,
    input  logic [AW-1:0] b_addr,
    input  logic [DW-1:0] b_wdata,
    output logic [DW-1:0] b_rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        a_rdata <= mem[a_addr];
        if (b_en) begin
            b_rdata <= mem[b_addr];
            if (b_we) mem[b_addr] <= b_wdata;
        end
        if (a_we) mem[a_addr] <= a_wdata;
    end
endmodule

// File: rtl/ring_ptrs.sv
module ring_ptrs #(
    parameter int AW = 6,
    parameter int N  = 5
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [N*AW-1:0] base_flat,
    input  logic [N-1:0]  adv,
    input  logic          wrap_hit,
    output logic [N*AW-1:0] ptr_flat
);
    for (genvar i = 0; i < N; i++) begin : g_ptr
        logic [AW-1:0] p;
        always_ff @(posedge clk) begin
            if (rst || load) begin
                p <= base_flat[i*AW +: AW];
            end else if (adv[i]) begin
                p <= wrap_hit ? base_flat[i*AW +: AW] : p + AW'(1);
            end
        end
        assign ptr_flat[i*AW +: AW] = p;
    end
endmodule

// File: rtl/ring_coalesce.sv
module ring_coalesce #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [CW-1:0] thresh,
    input  logic          frame_done,
    output logic          irq
);
    logic [CW-1:0] cnt;
    logic [CW-1:0] reload;

    assign reload = (thresh == '0) ? CW'(1) : thresh;

    always_ff @(posedge clk) begin
        if (rst || load) begin
            cnt <= reload;
            irq <= 1'b0;
        end else begin
            irq <= 1'b0;
            if (frame_done) begin
                if (cnt <= CW'(1)) begin
                    irq <= 1'b1;
                    cnt <= reload;
                end else begin
                    cnt <= cnt - CW'(1);
                end
            end
        end
    end
endmodule

// File: rtl/ring_event_writer.sv
module ring_event_writer
    import ring_pkg::*;
#(
    parameter int AW  = 6,
    parameter int NCH = 16,
    parameter int CW  = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 en,
    input  logic [AW-1:0]        tx_base,
    input  logic [NRXQ*AW-1:0]   rx_base,
    input  logic [2*NCH-1:0]     chan_qmap,
    input  logic [CW-1:0]        rx_thresh,
    input  logic                 tx_ev_valid,
    output logic                 tx_ev_ready,
    input  logic [CHAN_W-1:0]    tx_ev_chan,
    input  logic [FLAG_W-1:0]    tx_ev_flags,
    input  logic                 rx_ev_valid,
    output logic                 rx_ev_ready,
    input  logic [CHAN_W-1:0]    rx_ev_chan,
    input  logic [FLAG_W-1:0]    rx_ev_flags,
    input  logic                 rx_ev_last,
    input  logic                 sw_en,
    input  logic                 sw_we,
    input  logic [AW-1:0]        sw_addr,
    input  logic [ENT_W-1:0]     sw_wdata,
    output logic [ENT_W-1:0]     sw_rdata,
    output logic                 tx_irq,
    output logic                 rx_irq,
    output logic [NQ-1:0]        ovf
);
    localparam int CIW = (NCH > 1) ? $clog2(NCH) : 1;

    wr_state_e         state_q;
    logic [QW-1:0]     q_r;
    logic [CHAN_W-1:0] chan_r;
    logic [FLAG_W-1:0] flags_r;
    logic              is_rx_r;
    logic              last_r;

    logic              idle_en;
    logic              take_tx;
    logic              take_rx;
    logic [1:0]        rx_q;
    logic [QW-1:0]     sel_q;
    logic [QW-1:0]     rd_q;
    logic [NQ*AW-1:0]  ptr_flat;
    logic [NQ*AW-1:0]  base_flat;
    logic [NQ-1:0]     adv;

    logic [AW-1:0]     a_addr;
    logic              a_we;
    logic [ENT_W-1:0]  a_wdata;
    logic [ENT_W-1:0]  a_rdata;
    ring_entry_t       slot;

    // Handshake and arbitration: transmit has priority.
    assign idle_en     = (state_q == ST_IDLE) && en;
    assign tx_ev_ready = idle_en;
    assign rx_ev_ready = idle_en && !tx_ev_valid;
    assign take_tx     = tx_ev_ready && tx_ev_valid;
    assign take_rx     = rx_ev_ready && rx_ev_valid;

    assign rx_q  = chan_qmap[{rx_ev_chan[CIW-1:0], 1'b0} +: 2];
    assign sel_q = take_tx ? '0 : QW'(rx_q) + QW'(1);
    assign rd_q  = (state_q == ST_CHECK) ? q_r : sel_q;

    assign base_flat = {rx_base, tx_base};
    assign a_addr    = ptr_flat[rd_q*AW +: AW];

    // Ownership check and record formatting.
    assign slot    = ring_entry_t'(a_rdata);
    assign a_we    = (state_q == ST_CHECK) && en && !slot.valid;
    assign a_wdata = make_entry(slot.wrap, flags_r, chan_r);
    assign adv     = a_we ? (NQ'(1) << q_r) : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            q_r     <= '0;
            chan_r  <= '0;
            flags_r <= '0;
            is_rx_r <= 1'b0;
            last_r  <= 1'b0;
            ovf     <= '0;
            tx_irq  <= 1'b0;
        end else begin
            ovf    <= '0;
            tx_irq <= a_we && !is_rx_r;
            case (state_q)
                ST_IDLE: begin
                    if (take_tx || take_rx) begin
                        q_r     <= sel_q;
                        chan_r  <= take_tx ? tx_ev_chan : rx_ev_chan;
                        flags_r <= take_tx ? tx_ev_flags : rx_ev_flags;
                        is_rx_r <= !take_tx;
                        last_r  <= !take_tx && rx_ev_last;
                        state_q <= ST_CHECK;
                    end
                end
                ST_CHECK: begin
                    if (en && slot.valid) ovf <= NQ'(1) << q_r;
                    state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    ring_ptrs #(.AW(AW), .N(NQ)) u_ptrs (
        .clk       (clk),
        .rst       (rst),
        .load      (!en),
        .base_flat (base_flat),
        .adv       (adv),
        .wrap_hit  (slot.wrap),
        .ptr_flat  (ptr_flat)
    );

    ring_coalesce #(.CW(CW)) u_coal (
        .clk        (clk),
        .rst        (rst),
        .load       (!en),
        .thresh     (rx_thresh),
        .frame_done (a_we && is_rx_r && last_r),
        .irq        (rx_irq)
    );

    ring_ram #(.AW(AW), .DW(ENT_W)) u_ram (
        .clk     (clk),
        .a_addr  (a_addr),
        .a_we    (a_we),
        .a_wdata (a_wdata),
        .a_rdata (a_rdata),
        .b_en    (sw_en),
        .b_we    (sw_we),
        .b_addr  (sw_addr),
        .b_wdata (sw_wdata),
        .b_rdata (sw_rdata)
    );
endmodule

// File: rtl/ring_event_writer_chk.sv
module ring_event_writer_chk (
    input logic        clk,
    input logic        rst,
    input logic        tx_ev_valid,
    input logic        tx_ev_ready,
    input logic        rx_ev_valid,
    input logic        rx_ev_ready,
    input logic        rx_irq,
    input logic [4:0]  ovf,
    input logic        a_we,
    input logic [31:0] a_wdata
);
    // R1: every written record carries valid=1 and a zero pad
    a_r1_record_format: assert property (@(posedge clk) disable iff (rst)
        a_we |-> (a_wdata[31] && a_wdata[5:0] == 6'd0));

    // R5: an overflow is never paired with a write of the held slot
    a_r5_held_slot_kept: assert property (@(posedge clk) disable iff (rst)
        (|ovf) |-> !$past(a_we));

    // R6: at most one table overflows per cycle
    a_r6_ovf_onehot: assert property (@(posedge clk) disable iff (rst)
        $onehot0(ovf));

    // R7: receive is never offered while transmit waits
    a_r7_tx_first: assert property (@(posedge clk) disable iff (rst)
        tx_ev_valid |-> !rx_ev_ready);

    // R8: an accepted event blocks both sources for the next cycle
    a_r8_busy_after_accept: assert property (@(posedge clk) disable iff (rst)
        ((tx_ev_valid && tx_ev_ready) || (rx_ev_valid && rx_ev_ready))
        |=> (!tx_ev_ready && !rx_ev_ready));

    // R4: receive interrupt is a single-cycle pulse
    a_r4_irq_pulse: assert property (@(posedge clk) disable iff (rst)
        rx_irq |=> !rx_irq);
endmodule

bind ring_event_writer ring_event_writer_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .tx_ev_valid (tx_ev_valid),
    .tx_ev_ready (tx_ev_ready),
    .rx_ev_valid (rx_ev_valid),
    .rx_ev_ready (rx_ev_ready),
    .rx_irq      (rx_irq),
    .ovf         (ovf),
    .a_we        (a_we),
    .a_wdata     (a_wdata)
);

// File: tb/tb_ring_event_writer.sv
module tb_ring_event_writer;
    localparam int AW = 6;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        en  = 1'b0;
    logic [AW-1:0]   tx_base;
    logic [4*AW-1:0] rx_base;
    logic [31:0] chan_qmap;
    logic [15:0] rx_thresh;
    logic        tx_ev_valid = 1'b0, rx_ev_valid = 1'b0, rx_ev_last = 1'b0;
    logic        tx_ev_ready, rx_ev_ready;
    logic [7:0]  tx_ev_chan = '0, rx_ev_chan = '0;
    logic [15:0] tx_ev_flags = '0, rx_ev_flags = '0;
    logic        sw_en = 1'b0, sw_we = 1'b0;
    logic [AW-1:0] sw_addr = '0;
    logic [31:0] sw_wdata = '0, sw_rdata;
    logic        tx_irq, rx_irq;
    logic [4:0]  ovf;

    ring_event_writer #(.AW(AW), .NCH(16), .CW(16)) dut (
        .clk(clk), .rst(rst), .en(en), .tx_base(tx_base), .rx_base(rx_base),
        .chan_qmap(chan_qmap), .rx_thresh(rx_thresh),
        .tx_ev_valid(tx_ev_valid), .tx_ev_ready(tx_ev_ready),
        .tx_ev_chan(tx_ev_chan), .tx_ev_flags(tx_ev_flags),
        .rx_ev_valid(rx_ev_valid), .rx_ev_ready(rx_ev_ready),
        .rx_ev_chan(rx_ev_chan), .rx_ev_flags(rx_ev_flags), .rx_ev_last(rx_ev_last),
        .sw_en(sw_en), .sw_we(sw_we), .sw_addr(sw_addr), .sw_wdata(sw_wdata),
        .sw_rdata(sw_rdata), .tx_irq(tx_irq), .rx_irq(rx_irq), .ovf(ovf)
    );

    always #5 clk = ~clk;

    int n_cmp = 0;
    int n_bad = 0;
    int cycles = 0;

    // Table layout: index 0 transmit, 1..4 receive queues 0..3
    int mbase [5] = '{0, 8, 16, 24, 32};
    int mlen  [5] = '{4, 4, 2, 3, 4};
    int mptr  [5];
    int sptr  [5];
    bit occ   [5][8];
    logic [31:0] expq [5][$];
    int mthr;
    int mcnt;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 50000) begin
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=<50000 cycles", cycles);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    task automatic sw_write(input int addr, input logic [31:0] d);
        @(negedge clk);
        sw_en = 1'b1; sw_we = 1'b1; sw_addr = AW'(addr); sw_wdata = d;
        @(posedge clk);
        @(negedge clk);
        sw_en = 1'b0; sw_we = 1'b0;
    endtask

    task automatic sw_read(input int addr, output logic [31:0] d);
        @(negedge clk);
        sw_en = 1'b1; sw_we = 1'b0; sw_addr = AW'(addr);
        @(posedge clk);
        @(negedge clk);
        d = sw_rdata;
        sw_en = 1'b0;
    endtask

    // Model of one event: returns expected overflow vector and interrupts.
    task automatic predict(input bit is_tx, input logic [7:0] ch, input logic [15:0] fl,
                           input bit last, output logic [4:0] eovf, output bit eirq,
                           output bit etx);
        int q;
        bit w;
        q = is_tx ? 0 : 1 + int'(ch[1:0]);
        eovf = '0; eirq = 1'b0; etx = 1'b0;
        if (occ[q][mptr[q]]) begin
            eovf = 5'(1 << q);
        end else begin
            w = (mptr[q] == mlen[q] - 1);
            expq[q].push_back({1'b1, w, fl, ch, 6'd0});
            occ[q][mptr[q]] = 1'b1;
            mptr[q] = w ? 0 : mptr[q] + 1;
            etx = is_tx;
            if (!is_tx && last) begin
                mcnt--;
                if (mcnt == 0) begin
                    eirq = 1'b1;
                    mcnt = mthr;
                end
            end
        end
    endtask

    task automatic send(input bit is_tx, input logic [7:0] ch, input logic [15:0] fl,
                        input bit last, input string tag);
        logic [4:0] eovf;
        bit eirq, etx;
        predict(is_tx, ch, fl, last, eovf, eirq, etx);
        @(negedge clk);
        if (is_tx) begin
            tx_ev_valid = 1'b1; tx_ev_chan = ch; tx_ev_flags = fl;
        end else begin
            rx_ev_valid = 1'b1; rx_ev_chan = ch; rx_ev_flags = fl; rx_ev_last = last;
        end
        #1;
        while (!(is_tx ? tx_ev_ready : rx_ev_ready)) begin
            @(negedge clk);
            #1;
        end
        @(posedge clk);
        @(negedge clk);
        tx_ev_valid = 1'b0; rx_ev_valid = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check({tag, " R6 ovf"}, 32'(ovf), 32'(eovf));
        check({tag, " R4 rx_irq"}, 32'(rx_irq), 32'(eirq));
        check({tag, " R10 tx_irq"}, 32'(tx_irq), 32'(etx));
    endtask

    // Software monitor: pop expected records of one table and release slots.
    task automatic drain(input int q, input string tag);
        logic [31:0] d;
        bit w;
        while (expq[q].size() > 0) begin
            logic [31:0] e;
            e = expq[q].pop_front();
            sw_read(mbase[q] + sptr[q], d);
            check({tag, " R1 R2 R3 record"}, d, e);
            w = (sptr[q] == mlen[q] - 1);
            sw_write(mbase[q] + sptr[q], {1'b0, w, 30'd0});
            occ[q][sptr[q]] = 1'b0;
            sptr[q] = w ? 0 : sptr[q] + 1;
        end
    endtask

    task automatic reset_model();
        for (int q = 0; q < 5; q++) begin
            mptr[q] = 0;
            sptr[q] = 0;
        end
        mcnt = mthr;
    endtask

    initial begin
        logic [4:0] eo1, eo2;
        bit ei1, ei2, et1, et2;
        logic [31:0] d;

        tx_base = AW'(mbase[0]);
        rx_base = {AW'(mbase[4]), AW'(mbase[3]), AW'(mbase[2]), AW'(mbase[1])};
        for (int c = 0; c < 16; c++) chan_qmap[2*c +: 2] = 2'(c % 4);
        rx_thresh = 16'd3;
        mthr = 3;
        reset_model();
        for (int q = 0; q < 5; q++)
            for (int i = 0; i < 8; i++) occ[q][i] = 1'b0;

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        for (int q = 0; q < 5; q++)
            for (int i = 0; i < mlen[q]; i++)
                sw_write(mbase[q] + i, {1'b0, (i == mlen[q] - 1), 30'd0});

        @(negedge clk);
        #1;
        check("R9 no ready while disabled", {30'd0, tx_ev_ready, rx_ev_ready}, 32'd0);
        check("reset ovf/irq", {25'd0, ovf, tx_irq, rx_irq}, 32'd0);

        en = 1'b1;
        // Transmit records
        send(1, 8'h11, 16'hA5A5, 0, "tx0");
        send(1, 8'h22, 16'h0001, 0, "tx1");
        send(1, 8'hFF, 16'hFFFF, 0, "tx2");
        drain(0, "tx");

        // Receive queue 1 (length 2): third event overflows
        send(0, 8'd1, 16'h1234, 1, "q1a");
        send(0, 8'd5, 16'h5678, 1, "q1b");
        send(0, 8'd9, 16'h9ABC, 1, "q1c overflow");
        drain(2, "q1 held R5");
        send(0, 8'd13, 16'hDEF0, 1, "q1d wrap irq");
        drain(2, "q1 wrapped R2");

        // Routing to the other receive queues
        send(0, 8'd0, 16'h0F0F, 0, "q0");
        send(0, 8'd2, 16'hF0F0, 0, "q2");
        send(0, 8'd3, 16'h3333, 0, "q3");
        send(0, 8'd7, 16'h7777, 1, "q3b");
        drain(1, "q0 R3");
        drain(3, "q2 R3");
        drain(4, "q3 R3");

        // Transmit wrap across the end slot
        send(1, 8'h44, 16'h4444, 0, "tx3 end slot");
        send(1, 8'h55, 16'h5555, 0, "tx4 at base");
        drain(0, "tx wrap R2");

        // Simultaneous events: transmit first
        predict(1, 8'h66, 16'h6666, 0, eo1, ei1, et1);
        predict(0, 8'd4, 16'h4040, 1, eo2, ei2, et2);
        @(negedge clk);
        tx_ev_valid = 1'b1; tx_ev_chan = 8'h66; tx_ev_flags = 16'h6666;
        rx_ev_valid = 1'b1; rx_ev_chan = 8'd4; rx_ev_flags = 16'h4040; rx_ev_last = 1'b1;
        #1;
        check("R7 tx granted first", {30'd0, tx_ev_ready, rx_ev_ready}, 32'd2);
        @(posedge clk);
        @(negedge clk);
        tx_ev_valid = 1'b0;
        #1;
        check("R8 busy after accept", {30'd0, tx_ev_ready, rx_ev_ready}, 32'd0);
        @(posedge clk);
        @(negedge clk);
        #1;
        check("R10 tx_irq with rx offered", {30'd0, tx_irq, rx_ev_ready}, {30'd0, et1, 1'b1});
        @(posedge clk);
        @(negedge clk);
        rx_ev_valid = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check("R4 rx_irq after collision", 32'(rx_irq), 32'(ei2));
        check("R6 no ovf after collision", 32'(ovf), 32'(eo2));
        drain(0, "tx collide");
        drain(1, "q0 collide");

        // Disable, threshold 0, re-enable: pointers back to base
        drain(4, "q3 flush");
        @(negedge clk);
        en = 1'b0;
        rx_thresh = 16'd0;
        mthr = 1;
        @(negedge clk);
        #1;
        check("R9 disabled not ready", {30'd0, tx_ev_ready, rx_ev_ready}, 32'd0);
        reset_model();
        for (int q = 0; q < 5; q++)
            for (int i = 0; i < mlen[q]; i++)
                sw_write(mbase[q] + i, {1'b0, (i == mlen[q] - 1), 30'd0});
        @(negedge clk);
        en = 1'b1;
        send(0, 8'd2, 16'hBEEF, 1, "thr0 irq R9");
        send(0, 8'd6, 16'hCAFE, 1, "thr0 irq2");
        drain(3, "q2 base R9");
        sw_read(mbase[3] + 2, d);
        check("R5 untouched free slot", d, {1'b0, 1'b1, 30'd0});

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule